// File: doc/BRIEF.md
# UART receiver with break detection

This block turns an asynchronous serial receive line into 8-bit characters, each delivered with its own error flags. The line is first passed through a short synchronizer and then watched on every pulse of an external oversampling tick that runs at sixteen times the bit rate. A state machine finds a start bit, confirms it half a bit later, and then samples each data bit, the optional parity bit and the stop bit at the middle of its bit period. Data bits are shifted in least significant bit first.

Each finished character is shown on the output for one clock, together with three flags: framing error, parity error and break. Parity checking can be turned off or set to even, odd or stick mode through three static control inputs. A line that stays low for a whole character produces one all-zero character marked as a break. The receiver then ignores the line until it has gone back to the idle high level. An enable input gates only the acceptance of new start bits, so a character already in progress always completes.

States: `RX_IDLE` (waiting for a low line while enabled), `RX_START` (counting to mid-start), `RX_DATA` (eight data samples), `RX_PARITY` (one parity sample), `RX_STOP` (stop sample and result), `RX_HOLD` (locked after a break). Transitions:
- idle→start on a tick with the line low and enable high.
- start→idle if the line is high at mid-start; start→data if it is still low.
- data→parity or data→stop after the eighth data sample.
- parity→stop after the parity sample.
- stop→idle after a normal character; stop→hold after a break.
- hold→idle once the line is high.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is 0x00 and all three flags are 0.
- R2: Each completed character raises `rx_valid` for exactly one clock. `rx_data` holds the eight data bits, the first received bit at bit 0, each sampled at the middle of its bit period.
- R3: A start bit is accepted only if the synchronized line is still low on the 8th tick after the falling edge was seen. Otherwise the receiver returns to idle and produces no output.
- R4: A character whose stop bit samples as 0, and which is not a break, has `rx_frame_err` set and `rx_brk` clear.
- R5: With `par_en`=1 and `par_stick`=0, one parity bit follows the data. The expected value is the XOR of the 8 data bits when `par_even`=1, and its inverse when `par_even`=0. `rx_par_err` is 1 exactly when the received bit differs from the expected value.
- R6: With `par_en`=1 and `par_stick`=1, the expected parity bit is the inverse of `par_even`. A mismatch sets `rx_par_err`.
- R7: With `par_en`=0, no parity bit is expected: the stop bit directly follows data bit 7, and `rx_par_err` is always 0.
- R8: If the start, data, parity (when enabled) and stop samples are all 0, one character is produced with `rx_data`=0x00, `rx_brk`=1, `rx_frame_err`=0 and `rx_par_err`=0.
- R9: After a break, no further character is produced while the line stays low. Only a return to high followed by a new valid start bit produces the next character.
- R10: While `rx_en`=0 the receiver does not leave idle. Deasserting `rx_en` during a character still lets that character complete and be delivered.
- R11: Bit timing advances only on `baud_tick`. Characters are received correctly whether the tick comes every clock or every third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling pulse, 16 per bit period |
| rx_en | input | 1 | Allows new characters to start |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | A parity bit follows the data |
| par_even | input | 1 | Even parity select (stick: expected bit is its inverse) |
| par_stick | input | 1 | Stick parity mode |
| rx_valid | output | 1 | One-clock pulse per completed character |
| rx_data | output | 8 | Received character |
| rx_frame_err | output | 1 | Stop bit was 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_brk | output | 1 | Character is a break |

## Verification
The bench keeps the default build: 16 ticks per bit, 8 data bits and a two-stage synchronizer. With a tick on every clock, one character takes under two hundred cycles. That is short enough to send all 256 data values without parity, and to cover all four parity modes with both a correct and a deliberately wrong parity bit. The same short characters make room for the rarer cases: breaks with and without parity, the lockout that follows a break, rejected glitch starts, enable dropped in mid-character, and a slower tick rate.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_parity_calc.sv
module rx_parity_calc #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_even,
    input  logic          par_stick,
    output logic          exp_bit
);
    always_comb begin
        if (par_stick)     exp_bit = ~par_even;
        else if (par_even) exp_bit = ^data;
        else               exp_bit = ~(^data);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          line,
    input  logic          par_en,
    input  logic          exp_par,
    output logic [DW-1:0] shift_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_frame,
    output logic          out_par,
    output logic          out_brk
);
    localparam int CW = $clog2(OVS);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] MID_C  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    rx_state_e       state, state_nx;
    logic [CW-1:0]   tcnt;
    logic [BW-1:0]   bit_idx;
    logic [DW-1:0]   shreg;
    logic            zero_run;
    logic            par_rx;
    logic            at_mid, at_end, brk_hit;

    assign at_mid     = tick && (tcnt == MID_C);
    assign at_end     = tick && (tcnt == LAST_C);
    assign brk_hit    = zero_run && !line;
    assign shift_data = shreg;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (en && tick && !line) state_nx = RX_START;
            RX_START:  if (at_mid) state_nx = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (at_end && bit_idx == LAST_BIT)
                           state_nx = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (at_end) state_nx = RX_STOP;
            RX_STOP:   if (at_end) state_nx = brk_hit ? RX_HOLD : RX_IDLE;
            RX_HOLD:   if (line) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            zero_run <= 1'b0;
            par_rx   <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                RX_IDLE: begin
                    tcnt    <= '0;
                    bit_idx <= '0;
                end
                RX_START: begin
                    if (at_mid) begin
                        tcnt     <= '0;
                        zero_run <= 1'b1;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) tcnt <= at_end ? '0 : tcnt + 1'b1;
                    if (at_end) begin
                        shreg    <= {line, shreg[DW-1:1]};
                        bit_idx  <= bit_idx + 1'b1;
                        zero_run <= zero_run & ~line;
                    end
                end
                RX_PARITY: begin
                    if (tick) tcnt <= at_end ? '0 : tcnt + 1'b1;
                    if (at_end) begin
                        par_rx   <= line;
                        zero_run <= zero_run & ~line;
                    end
                end
                RX_STOP: begin
                    if (tick) tcnt <= at_end ? '0 : tcnt + 1'b1;
                end
                RX_HOLD: begin
                    tcnt <= '0;
                end
                default: tcnt <= '0;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_frame <= 1'b0;
            out_par   <= 1'b0;
            out_brk   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (state == RX_STOP && at_end) begin
                out_valid <= 1'b1;
                if (brk_hit) begin
                    out_data  <= '0;
                    out_frame <= 1'b0;
                    out_par   <= 1'b0;
                    out_brk   <= 1'b1;
                end else begin
                    out_data  <= shreg;
                    out_frame <= !line;
                    out_par   <= par_en && (par_rx != exp_par);
                    out_brk   <= 1'b0;
                end
            end
        end
    end

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_start_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == RX_START && state == RX_DATA) |-> !$past(line));

    assert_par_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == RX_DATA && state == RX_PARITY) |-> $past(par_en));

    assert_break_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> (out_data == '0 && !out_frame && !out_par));

    assert_hold_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && $past(state) == RX_HOLD) |-> !out_valid);

    assert_idle_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !en) |=> state == RX_IDLE);

    assert_tick_pace_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != RX_IDLE && state != RX_HOLD) |=> $stable(tcnt));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rx_en,
    input  logic          rx_line,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          par_stick,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_frame_err,
    output logic          rx_par_err,
    output logic          rx_brk
);
    logic          line_s;
    logic          exp_par;
    logic [DW-1:0] shift_data;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_parity_calc #(.DW(DW)) u_par (
        .data     (shift_data),
        .par_even (par_even),
        .par_stick(par_stick),
        .exp_bit  (exp_par)
    );

    rx_frame_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .en        (rx_en),
        .line      (line_s),
        .par_en    (par_en),
        .exp_par   (exp_par),
        .shift_data(shift_data),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_frame (rx_frame_err),
        .out_par   (rx_par_err),
        .out_brk   (rx_brk)
    );
endmodule

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       rx_en = 1'b1;
    logic       rx_line = 1'b1;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_frame_err, rx_par_err, rx_brk;

    int checks = 0;
    int failures = 0;
    int div = 1;
    int tdiv_cnt = 0;
    int nvalid = 0;
    logic [7:0] cap_data = '0;
    logic cap_fe = 1'b0, cap_pe = 1'b0, cap_brk = 1'b0;

    always #5 clk = ~clk;

    uart_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
        .rx_line(rx_line), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk)
    );

    always @(posedge clk) tdiv_cnt <= (tdiv_cnt >= div - 1) ? 0 : tdiv_cnt + 1;
    assign baud_tick = (tdiv_cnt == div - 1);

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            nvalid   <= nvalid + 1;
            cap_data <= rx_data;
            cap_fe   <= rx_frame_err;
            cap_pe   <= rx_par_err;
            cap_brk  <= rx_brk;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (16 * div) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input bit use_par, input logic pbit, input logic sbit);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (use_par) drive_bit(pbit);
        drive_bit(sbit);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic expect_char(input int n0, input logic [7:0] d, input logic fe, input logic pe,
                               input logic bk, input string tag);
        logic [23:0] act, exp;
        act = {8'(nvalid - n0), cap_data, 5'b0, cap_fe, cap_pe, cap_brk};
        exp = {8'd1, d, 5'b0, fe, pe, bk};
        check(act == exp, tag, 32'(act), 32'(exp));
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic even, input logic stick);
        if (stick) return ~even;
        return even ? ^d : ~(^d);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({rx_valid, rx_data, rx_frame_err, rx_par_err, rx_brk} == 12'h0, "R1 reset outputs",
              32'({rx_valid, rx_data, rx_frame_err, rx_par_err, rx_brk}), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(nvalid == 0, "R1 idle after reset", 32'(nvalid), 32'h0);

        // R2 R7: all 256 values without parity
        for (int v = 0; v < 256; v++) begin
            n0 = nvalid;
            send_char(8'(v), 1'b0, 1'b0, 1'b1);
            expect_char(n0, 8'(v), 1'b0, 1'b0, 1'b0, "R2 R7 no-parity sweep");
        end

        // R5 R6: parity modes with good and bad parity bit
        par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            par_stick = (m >= 2);
            par_even  = (m == 0) || (m == 2);
            for (int k = 0; k < 16; k++) begin
                for (int bad = 0; bad < 2; bad++) begin
                    logic [7:0] d;
                    logic pb;
                    d  = 8'((k * 37 + 11 + m * 5) & 255);
                    pb = exp_parity(d, par_even, par_stick) ^ bad[0];
                    n0 = nvalid;
                    send_char(d, 1'b1, pb, 1'b1);
                    expect_char(n0, d, 1'b0, bad[0], 1'b0, par_stick ? "R6 stick parity" : "R5 even/odd parity");
                end
            end
        end

        // R8 R9: break with parity enabled, then lockout
        par_stick = 1'b0; par_even = 1'b1;
        n0 = nvalid;
        rx_line = 1'b0;
        repeat (16 * 12 * div) @(negedge clk);
        expect_char(n0, 8'h00, 1'b0, 1'b0, 1'b1, "R8 break with parity");
        repeat (16 * 15 * div) @(negedge clk);
        check(nvalid == n0 + 1, "R9 locked while low", 32'(nvalid - n0), 32'd1);
        drive_bit(1'b1);
        n0 = nvalid;
        send_char(8'h5C, 1'b1, exp_parity(8'h5C, 1'b1, 1'b0), 1'b1);
        expect_char(n0, 8'h5C, 1'b0, 1'b0, 1'b0, "R9 recovery after break");

        // R4: framing errors
        par_en = 1'b0;
        for (int k = 1; k < 5; k++) begin
            n0 = nvalid;
            send_char(8'(k * 51), 1'b0, 1'b0, 1'b0);
            expect_char(n0, 8'(k * 51), 1'b1, 1'b0, 1'b0, "R4 framing error");
        end

        // R8: break without parity, zero data but good stop is not a break
        n0 = nvalid;
        rx_line = 1'b0;
        repeat (16 * 14 * div) @(negedge clk);
        expect_char(n0, 8'h00, 1'b0, 1'b0, 1'b1, "R8 break no parity");
        drive_bit(1'b1);
        n0 = nvalid;
        send_char(8'h00, 1'b0, 1'b0, 1'b1);
        expect_char(n0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 zero char not break");

        // R3: glitch start rejected
        n0 = nvalid;
        rx_line = 1'b0;
        repeat (5 * div) @(negedge clk);
        drive_bit(1'b1);
        drive_bit(1'b1);
        check(nvalid == n0, "R3 glitch rejected", 32'(nvalid - n0), 32'd0);
        send_char(8'hC3, 1'b0, 1'b0, 1'b1);
        expect_char(n0, 8'hC3, 1'b0, 1'b0, 1'b0, "R3 start after glitch");

        // R10: disabled idle, then drop mid-character
        rx_en = 1'b0;
        n0 = nvalid;
        send_char(8'h3A, 1'b0, 1'b0, 1'b1);
        check(nvalid == n0, "R10 disabled ignores", 32'(nvalid - n0), 32'd0);
        rx_en = 1'b1;
        n0 = nvalid;
        fork
            send_char(8'h96, 1'b0, 1'b0, 1'b1);
            begin
                repeat (16 * 3 * div) @(negedge clk);
                rx_en = 1'b0;
            end
        join
        expect_char(n0, 8'h96, 1'b0, 1'b0, 1'b0, "R10 finish after disable");
        n0 = nvalid;
        send_char(8'h69, 1'b0, 1'b0, 1'b1);
        check(nvalid == n0, "R10 stays idle", 32'(nvalid - n0), 32'd0);
        rx_en = 1'b1;

        // R11: slower tick
        div = 3;
        drive_bit(1'b1);
        for (int k = 0; k < 4; k++) begin
            n0 = nvalid;
            send_char(8'(8'hA5 ^ (k * 29)), 1'b0, 1'b0, 1'b1);
            expect_char(n0, 8'(8'hA5 ^ (k * 29)), 1'b0, 1'b0, 1'b0, "R11 tick every third clock");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule